// File: doc/BRIEF.md
# SPI FIFO Word Packer and Unpacker

This block sits between a byte-oriented client and the 32-bit transmit and receive FIFOs of an SPI serial engine. The engine's word length is set from 4 to 32 bits, and the block uses it to work out how many bytes make up one FIFO word: 1, 2 or 4. On the transmit side it gathers that many client bytes into one 32-bit word and pushes it into the output FIFO. On the receive side it pops a 32-bit word from the input FIFO and hands its bytes to the client one at a time. Both client byte streams use a valid/ready handshake.

A transfer starts with a one-cycle `cfg_start` pulse. The pulse carries the word-length field, the transfer length in bytes, and two flags that say whether a transmit source and a receive sink exist. With no transmit source, the block pushes all-zero filler words. With no receive sink, it pops received words and drops them. The transfer ends when the count of received bytes reaches the transfer length. A bad configuration is rejected with an error flag and starts nothing.

Top module: `spi_word_packer`

## Requirements
- R1: `cfg_wlen_m1` holds bits-per-word minus 1. Field values 3..7 give 1 byte per word, 8..15 give 2 bytes, and 16..31 give 4 bytes. A transfer of L bytes moves exactly L/w words in each direction, where w is the bytes per word.
- R2: On transmit, byte i of a word (i counts from 0 in stream order) goes to bits [8*(3-i)+7 : 8*(3-i)], so the first byte lands in bits 31:24. Bytes not used in the word are zero.
- R3: On receive, the word is right-aligned. Byte i comes from bits [8*(w-1-i)+7 : 8*(w-1-i)], and bytes are delivered in increasing i. While `rx_byte_ready` is low, `rx_byte` stays stable.
- R4: `ofifo_push` is never asserted while `ofifo_full` is high. A completed word waits, unchanged, until the FIFO is no longer full.
- R5: `ififo_pop` is never asserted while `ififo_empty` is high. Unpacking resumes when the FIFO is no longer empty.
- R6: If `cfg_tx_present` is 0, the block pushes L/w all-zero words and `tx_byte_ready` stays low.
- R7: If `cfg_rx_present` is 0, the block still pops L/w words. It drops each one, counts it as w bytes, and never raises `rx_byte_valid`.
- R8: `done` pulses for one cycle once the received byte count equals the transfer length. From that cycle on, `busy` is low.
- R9: `cfg_start` sets `cfg_err` and starts no transfer if the length is not a multiple of w or if the field is below 3. `cfg_err` stays set until the next valid start clears it.
- R10: After reset, `busy`, `cfg_err`, `ofifo_push`, `ififo_pop`, `rx_byte_valid` and `tx_byte_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle pulse that starts a transfer |
| cfg_wlen_m1 | input | 5 | Bits per word minus 1 |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_tx_present | input | 1 | A transmit byte source exists |
| cfg_rx_present | input | 1 | A receive byte sink exists |
| cfg_err | output | 1 | The last start was rejected |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the transfer completes |
| tx_byte_valid | input | 1 | Transmit byte is valid |
| tx_byte_ready | output | 1 | Block accepts a transmit byte |
| tx_byte | input | 8 | Transmit byte |
| ofifo_full | input | 1 | Output FIFO is full |
| ofifo_push | output | 1 | Push `ofifo_word` into the output FIFO |
| ofifo_word | output | 32 | Packed transmit word |
| ififo_empty | input | 1 | Input FIFO is empty |
| ififo_pop | output | 1 | Pop the head word of the input FIFO |
| ififo_word | input | 32 | Head word of the input FIFO |
| rx_byte_valid | output | 1 | Receive byte is valid |
| rx_byte_ready | input | 1 | Client accepts the receive byte |
| rx_byte | output | 8 | Receive byte |

## Verification
The bench sweeps every legal word-length field from 3 to 31. Each field value is run with all four combinations of transmit source present or absent and receive sink present or absent. This separates the three byte widths and shows that transmit alignment (high bytes first) differs from receive alignment (right-aligned). Each run uses five-word transfers with distinct byte values, and the FIFO full and empty signals and the receive ready signal are stalled on different periodic patterns, so the stall handling is exercised at every byte position. A set of rejected configurations covers a bad length for each width and a field below 3, and checks that nothing moves afterwards.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int WORD_B    = WORD_W / BYTE_W;
    localparam int FIELD_W   = 5;
    localparam int FIELD_MIN = 3;

    typedef struct packed {
        logic [FIELD_W-1:0] wlen_m1;
        logic               tx_present;
        logic               rx_present;
    } xfer_cfg_t;

    // Bytes per FIFO word for a word-length field (bits-per-word minus 1).
    function automatic logic [2:0] bytes_for_field(input logic [FIELD_W-1:0] f);
        if (f <= 5'd7)       return 3'd1;
        else if (f <= 5'd15) return 3'd2;
        else                 return 3'd4;
    endfunction

    function automatic logic field_legal(input logic [FIELD_W-1:0] f);
        return f >= 5'(FIELD_MIN);
    endfunction
endpackage

// File: rtl/spi_tx_packer.sv
module spi_tx_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic              tx_present,
    input  logic [2:0]        w,
    input  logic [LEN_W-1:0]  len,
    input  logic              tx_byte_valid,
    output logic              tx_byte_ready,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              ofifo_full,
    output logic              ofifo_push,
    output logic [WORD_W-1:0] ofifo_word
);
    localparam int IDX_W = $clog2(WORD_B);

    logic [WORD_W-1:0] acc;
    logic [IDX_W-1:0]  idx;
    logic              pend;
    logic [LEN_W-1:0]  cnt;
    logic              room;
    logic              accept;
    logic              filler;

    assign room          = active && !pend && (cnt < len);
    assign tx_byte_ready = room && tx_present;
    assign accept        = tx_byte_ready && tx_byte_valid;
    assign filler        = room && !tx_present;
    assign ofifo_push    = pend && !ofifo_full;
    assign ofifo_word    = acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc  <= '0;
            idx  <= '0;
            pend <= 1'b0;
            cnt  <= '0;
        end else begin
            if (ofifo_push) begin
                pend <= 1'b0;
                acc  <= '0;
            end
            if (accept) begin
                for (int i = 0; i < WORD_B; i++) begin
                    if (idx == IDX_W'(i))
                        acc[BYTE_W*(WORD_B-1-i) +: BYTE_W] <= tx_byte;
                end
                cnt <= cnt + 1'b1;
                if ({1'b0, idx} == IDX_W'(w - 3'd1)) begin
                    idx  <= '0;
                    pend <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (filler) begin
                pend <= 1'b1;
                cnt  <= cnt + LEN_W'(w);
            end
        end
    end

    assert_hold_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (pend && ofifo_full && !clr) |=> (pend && $stable(ofifo_word)));

    assert_no_ready_without_source_R6: assert property (@(posedge clk) disable iff (rst)
        (!tx_present) |-> (!tx_byte_ready));
endmodule

// File: rtl/spi_rx_unpacker.sv
module spi_rx_unpacker
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic              rx_present,
    input  logic [2:0]        w,
    input  logic [LEN_W-1:0]  len,
    input  logic              ififo_empty,
    output logic              ififo_pop,
    input  logic [WORD_W-1:0] ififo_word,
    output logic              rx_byte_valid,
    input  logic              rx_byte_ready,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [LEN_W-1:0]  rx_count
);
    localparam int IDX_W = $clog2(WORD_B);

    logic [WORD_W-1:0] hold;
    logic              hv;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  cnt;
    logic [IDX_W-1:0]  shift;

    assign ififo_pop     = active && !ififo_empty && !hv && (cnt < len);
    assign rx_byte_valid = hv;
    assign rx_count      = cnt;
    assign shift         = IDX_W'(w - 3'd1) - idx;

    always_comb begin
        rx_byte = '0;
        for (int s = 0; s < WORD_B; s++) begin
            if (shift == IDX_W'(s))
                rx_byte = hold[BYTE_W*s +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold <= '0;
            hv   <= 1'b0;
            idx  <= '0;
            cnt  <= '0;
        end else begin
            if (ififo_pop) begin
                if (rx_present) begin
                    hold <= ififo_word;
                    hv   <= 1'b1;
                    idx  <= '0;
                end else begin
                    cnt <= cnt + LEN_W'(w);
                end
            end
            if (hv && rx_byte_ready) begin
                cnt <= cnt + 1'b1;
                if ({1'b0, idx} == IDX_W'(w - 3'd1)) begin
                    hv  <= 1'b0;
                    idx <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_stall_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_valid && !rx_byte_ready && !clr) |=> (rx_byte_valid && $stable(rx_byte)));

    assert_dropped_no_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (!rx_present && !clr) |=> (!rx_byte_valid || rx_present));

    assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (ififo_empty) |-> (!ififo_pop));
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_pack_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_start,
    input  logic [4:0]        cfg_wlen_m1,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_tx_present,
    input  logic              cfg_rx_present,
    output logic              cfg_err,
    output logic              busy,
    output logic              done,
    input  logic              tx_byte_valid,
    output logic              tx_byte_ready,
    input  logic [7:0]        tx_byte,
    input  logic              ofifo_full,
    output logic              ofifo_push,
    output logic [31:0]       ofifo_word,
    input  logic              ififo_empty,
    output logic              ififo_pop,
    input  logic [31:0]       ififo_word,
    output logic              rx_byte_valid,
    input  logic              rx_byte_ready,
    output logic [7:0]        rx_byte
);
    xfer_cfg_t        cfg_q;
    logic [LEN_W-1:0] len_q;
    logic [2:0]       w_q;
    logic             active;
    logic             err_q;
    logic             done_q;
    logic [2:0]       w_new;
    logic             start_ok;
    logic [LEN_W-1:0] rx_count;

    assign w_new    = bytes_for_field(cfg_wlen_m1);
    assign start_ok = field_legal(cfg_wlen_m1) &&
                      ((cfg_len & LEN_W'(w_new - 3'd1)) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            len_q  <= '0;
            w_q    <= 3'd1;
            active <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (cfg_start) begin
            cfg_q  <= '{wlen_m1: cfg_wlen_m1, tx_present: cfg_tx_present,
                        rx_present: cfg_rx_present};
            len_q  <= cfg_len;
            w_q    <= w_new;
            active <= start_ok;
            err_q  <= !start_ok;
            done_q <= 1'b0;
        end else begin
            done_q <= active && (rx_count == len_q);
            if (active && (rx_count == len_q))
                active <= 1'b0;
        end
    end

    assign busy    = active;
    assign cfg_err = err_q;
    assign done    = done_q;

    spi_tx_packer #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .clr(cfg_start), .active(active),
        .tx_present(cfg_q.tx_present), .w(w_q), .len(len_q),
        .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready), .tx_byte(tx_byte),
        .ofifo_full(ofifo_full), .ofifo_push(ofifo_push), .ofifo_word(ofifo_word)
    );

    spi_rx_unpacker #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .clr(cfg_start), .active(active),
        .rx_present(cfg_q.rx_present), .w(w_q), .len(len_q),
        .ififo_empty(ififo_empty), .ififo_pop(ififo_pop), .ififo_word(ififo_word),
        .rx_byte_valid(rx_byte_valid), .rx_byte_ready(rx_byte_ready), .rx_byte(rx_byte),
        .rx_count(rx_count)
    );

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_err_no_transfer_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!busy && !ofifo_push && !ififo_pop));

    assert_push_not_full_R4: assert property (@(posedge clk) disable iff (rst)
        (ofifo_full && !cfg_start) |=> ($stable(ofifo_word) || $past(!ofifo_push)));
endmodule

// File: tb/test_spi_word_packer.sv
`timescale 1ns/1ps
module test_spi_word_packer;
    localparam int LEN_W = 12;
    localparam int NW    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_start = 1'b0;
    logic [4:0] cfg_wlen_m1 = '0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic cfg_tx_present = 1'b0, cfg_rx_present = 1'b0;
    logic cfg_err, busy, done;
    logic tx_byte_valid = 1'b0, tx_byte_ready;
    logic [7:0] tx_byte = '0;
    logic ofifo_full = 1'b0, ofifo_push;
    logic [31:0] ofifo_word;
    logic ififo_empty = 1'b1, ififo_pop;
    logic [31:0] ififo_word = '0;
    logic rx_byte_valid, rx_byte_ready = 1'b0;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spi_word_packer #(.LEN_W(LEN_W)) i_spi_word_packer (.*);

    function automatic int bpw(input int f);
        return (f <= 7) ? 1 : (f <= 15) ? 2 : 4;
    endfunction
    function automatic logic [7:0] txv(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction
    function automatic logic [31:0] rxw(input int j);
        return (32'h9E3779B9 * 32'(j + 1)) ^ 32'h5A5AC3C3;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input int f, input int len, input bit txp, input bit rxp);
        @(posedge clk); #1;
        cfg_wlen_m1 = 5'(f); cfg_len = LEN_W'(len);
        cfg_tx_present = txp; cfg_rx_present = rxp; cfg_start = 1'b1;
        @(posedge clk); #1;
        cfg_start = 1'b0;
    endtask

    task automatic run_case(input int f, input bit txp, input bit rxp);
        int w = bpw(f);
        int len = w * NW;
        int k = 0, pushes = 0, pops = 0, rxb = 0, cyc = 0;
        bit fin = 0;
        logic [31:0] ew;
        start(f, len, txp, rxp);
        check(cfg_err == 1'b0 && busy == 1'b1, "R9", {cfg_err, busy}, 2'b01);
        while (!fin && cyc < 3000) begin
            tx_byte_valid = txp && (k < len);
            tx_byte       = txv(k);
            ofifo_full    = (cyc % 3 == 1);
            ififo_empty   = (pops >= pushes) || (cyc % 4 == 2);
            ififo_word    = rxw(pops);
            rx_byte_ready = (cyc % 5 != 3);
            @(negedge clk);
            if (tx_byte_ready && !txp) check(0, "R6", 1, 0);
            if (rx_byte_valid && !rxp) check(0, "R7", 1, 0);
            if (ofifo_push) begin
                check(!ofifo_full, "R4", ofifo_full, 0);
                ew = '0;
                for (int i = 0; i < w; i++)
                    if (txp) ew[8*(3-i) +: 8] = txv(pushes * w + i);
                if (txp) check(ofifo_word == ew, "R2", ofifo_word, ew);
                else     check(ofifo_word == 32'h0, "R6", ofifo_word, 0);
                pushes++;
            end
            if (ififo_pop) begin
                check(!ififo_empty, "R5", ififo_empty, 0);
                pops++;
            end
            if (rx_byte_valid && rx_byte_ready) begin
                logic [7:0] eb;
                eb = 8'(rxw(rxb / w) >> (8 * (w - 1 - (rxb % w))));
                check(rx_byte == eb, "R3", rx_byte, eb);
                rxb++;
            end
            if (tx_byte_valid && tx_byte_ready) k++;
            if (done) fin = 1;
            @(posedge clk); #1;
            cyc++;
        end
        tx_byte_valid = 1'b0; ofifo_full = 1'b0; ififo_empty = 1'b1; rx_byte_ready = 1'b0;
        check(fin, "R8", fin, 1);
        check(busy == 1'b0, "R8", busy, 0);
        check(pushes == NW, "R1", pushes, NW);
        check(pops == NW, "R1", pops, NW);
        check(rxb == (rxp ? len : 0), rxp ? "R3" : "R7", rxb, rxp ? len : 0);
        check(k == (txp ? len : 0), txp ? "R2" : "R6", k, txp ? len : 0);
    endtask

    task automatic bad_case(input int f, input int len);
        bit moved = 0;
        start(f, len, 1'b1, 1'b1);
        check(cfg_err == 1'b1, "R9", cfg_err, 1);
        check(busy == 1'b0, "R9", busy, 0);
        tx_byte_valid = 1'b1; ififo_empty = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (tx_byte_ready || ofifo_push || ififo_pop || rx_byte_valid) moved = 1;
        end
        tx_byte_valid = 1'b0; ififo_empty = 1'b1;
        check(!moved, "R9", moved, 0);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                check(0, "watchdog", 0, 1);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check({busy, cfg_err, ofifo_push, ififo_pop, rx_byte_valid, tx_byte_ready} == 6'b0,
              "R10", {busy, cfg_err, ofifo_push, ififo_pop, rx_byte_valid, tx_byte_ready}, 0);
        for (int f = 3; f <= 31; f++)
            for (int m = 0; m < 4; m++)
                run_case(f, m[0], m[1]);
        bad_case(12, 7);
        bad_case(20, 6);
        bad_case(31, 10);
        bad_case(2, 4);
        bad_case(0, 4);
        run_case(7, 1'b1, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule